// File: doc/BRIEF.md
# CAN Error Frame Signaller

This block generates the bit sequence a CAN node puts on the bus after a bus error has been detected. It works one bit at a time. A single-cycle bit strobe marks each bit boundary and all state advances only on strobe cycles. When an error is reported on a strobe while the block is idle, it takes a snapshot of the node's error status and of whether the node was transmitting. It then drives either a dominant flag or a recessive flag. It waits out any flag echo from other nodes and counts the recessive delimiter. A node that signalled as error-passive must also wait for a quiet bus before the frame counts as finished.

The bus encoding is 0 for dominant and 1 for recessive. The output bit is combined with the other nodes' bits on a wired-AND bus. The enclosing frame engine supplies the sampled bus bit for the current bit time together with the strobe. It reads back the in-progress flag, a pulse that requests a retry of an aborted transmission, and a pulse that reports an over-long dominant field.

Top module: `can_ef_gen`

## Requirements
- R1: After a synchronous reset the block is idle: `tx_bit` is 1 (recessive), `frame_active` is 0 and neither pulse output is asserted.
- R2: An error frame starts only when `err_detect` is high in a cycle where `bit_strobe` is high while idle. `frame_active` rises in the cycle after that strobe. `err_detect` in a cycle without a strobe has no effect.
- R3: With `err_passive` low at the start, `tx_bit` is 0 (dominant) for exactly the first FLAG_LEN (6) bit strobes of the frame and 1 afterwards.
- R4: With `err_passive` high at the start, `tx_bit` stays 1 for the whole frame.
- R5: After its own flag, the block waits while the bus reads 0. The delimiter begins with the first bus bit of 1. A dominant field of up to MAX_ECHO (12) bits counted from flag start raises no error.
- R6: If the dominant field counted from flag start reaches MAX_ECHO+1 (13) bits, `echo_overrun` pulses high for exactly one clock cycle.
- R7: The delimiter ends after DELIM_LEN (8) consecutive bus bits of 1. A bus bit of 0 inside the delimiter restarts the count from zero.
- R8: A frame started as error-passive is followed by a rejoin wait. The wait ends after REJOIN_LEN (6) consecutive bus bits of 1, and a 0 restarts it.
- R9: When the frame ends, `retry_req` pulses high for one cycle, in the cycle in which `frame_active` falls, only if `node_tx` was high at the starting strobe.
- R10: While a frame is in progress, `err_detect` and changes of `err_passive` do not change the frame's length, flag type or retry decision.
- R11: `frame_active` stays high from the first flag bit through the delimiter and, for passive frames, through the rejoin wait. It falls in the cycle after the strobe that completes the frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_strobe | input | 1 | One-cycle pulse per bit time |
| bus_bit | input | 1 | Sampled bus level of the current bit (0 dominant) |
| err_detect | input | 1 | Bus error seen (sampled with the strobe) |
| err_passive | input | 1 | Node error state: 1 passive, 0 active |
| node_tx | input | 1 | Node was transmitting when the error was seen |
| tx_bit | output | 1 | Bit to drive onto the bus |
| frame_active | output | 1 | Error frame or rejoin wait in progress |
| retry_req | output | 1 | One-cycle pulse: resend the aborted message |
| echo_overrun | output | 1 | One-cycle pulse: dominant field exceeded its limit |

## Verification
The bench builds the block with its default parameters: a six-bit flag, an eight-bit delimiter, an echo limit of twelve, a six-bit rejoin wait, and the echo limit check enabled. These short lengths let every field boundary be driven directly. The bench covers an echo that just fits, one bit of overrun, a dominant bit that restarts the delimiter, and a dominant bit that restarts the rejoin wait. Each of these cases changes the frame length by a known number of strobes, and the bench checks that length.

// File: rtl/can_ef_pkg.sv
package can_ef_pkg;

   typedef enum logic [2:0] {
      EF_IDLE   = 3'd0,
      EF_FLAG   = 3'd1,
      EF_ECHO   = 3'd2,
      EF_DELIM  = 3'd3,
      EF_REJOIN = 3'd4
   } ef_state_e;

   function automatic int unsigned ef_max3(input int unsigned a,
                                           input int unsigned b,
                                           input int unsigned c);
      int unsigned m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/can_ef_runcnt.sv
module can_ef_runcnt #(
   parameter int unsigned W = 4
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         en,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] cnt
);

   localparam logic [W-1:0] TOP = {W{1'b1}};

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt <= '0;
      end else if (en) begin
         if (clr) begin
            cnt <= inc ? W'(1) : '0;
         end else if (inc && (cnt != TOP)) begin
            cnt <= cnt + W'(1);
         end
      end
   end

endmodule

// File: rtl/can_ef_drive.sv
module can_ef_drive
   import can_ef_pkg::*;
(
   input  ef_state_e state,
   input  logic      passive_q,
   output logic      tx_bit
);

   always_comb begin
      tx_bit = 1'b1;
      if ((state == EF_FLAG) && !passive_q) begin
         tx_bit = 1'b0;
      end
   end

endmodule

// File: rtl/can_ef_gen.sv
module can_ef_gen
   import can_ef_pkg::*;
#(
   parameter int unsigned FLAG_LEN      = 6,
   parameter int unsigned DELIM_LEN     = 8,
   parameter int unsigned MAX_ECHO      = 12,
   parameter int unsigned REJOIN_LEN    = 6,
   parameter bit          ECHO_CHECK_EN = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic bit_strobe,
   input  logic bus_bit,
   input  logic err_detect,
   input  logic err_passive,
   input  logic node_tx,
   output logic tx_bit,
   output logic frame_active,
   output logic retry_req,
   output logic echo_overrun
);

   localparam int unsigned MAXV  = ef_max3(MAX_ECHO, DELIM_LEN, REJOIN_LEN);
   localparam int unsigned CNT_W = $clog2(MAXV + 2);

   localparam logic [CNT_W-1:0] FLAG_LAST   = CNT_W'(FLAG_LEN - 1);
   localparam logic [CNT_W-1:0] DELIM_LAST  = CNT_W'(DELIM_LEN - 1);
   localparam logic [CNT_W-1:0] REJOIN_LAST = CNT_W'(REJOIN_LEN - 1);
   localparam logic [CNT_W-1:0] ECHO_LIMIT  = CNT_W'(MAX_ECHO);

   if (FLAG_LEN < 1) begin : g_bad_flag
      $error("FLAG_LEN must be at least 1");
   end
   if (DELIM_LEN < 1) begin : g_bad_delim
      $error("DELIM_LEN must be at least 1");
   end
   if (REJOIN_LEN < 1) begin : g_bad_rejoin
      $error("REJOIN_LEN must be at least 1");
   end
   if (MAX_ECHO < FLAG_LEN) begin : g_bad_echo
      $error("MAX_ECHO must not be below FLAG_LEN");
   end

   ef_state_e state, state_n;
   logic      passive_q, pend_q;
   logic      fclr, finc, dclr, dinc, rclr, rinc;
   logic      delim_done, release_now, ovr_hit;
   logic [CNT_W-1:0] fcnt, dcnt, rcnt;

   // field counter: bits since flag start while the dominant field lasts
   can_ef_runcnt #(.W(CNT_W)) i_field_cnt (
      .clk (clk), .rst (rst), .en (bit_strobe),
      .clr (fclr), .inc (finc), .cnt (fcnt)
   );

   // delimiter counter: consecutive recessive bits in the delimiter
   can_ef_runcnt #(.W(CNT_W)) i_delim_cnt (
      .clk (clk), .rst (rst), .en (bit_strobe),
      .clr (dclr), .inc (dinc), .cnt (dcnt)
   );

   // rejoin counter: consecutive recessive bits after a passive frame
   can_ef_runcnt #(.W(CNT_W)) i_rejoin_cnt (
      .clk (clk), .rst (rst), .en (bit_strobe),
      .clr (rclr), .inc (rinc), .cnt (rcnt)
   );

   always_comb begin
      state_n     = state;
      fclr        = 1'b0;
      finc        = 1'b0;
      dclr        = 1'b0;
      dinc        = 1'b0;
      rclr        = 1'b0;
      rinc        = 1'b0;
      delim_done  = 1'b0;
      release_now = 1'b0;
      ovr_hit     = 1'b0;
      if (bit_strobe) begin
         unique case (state)
            EF_IDLE: begin
               if (err_detect) begin
                  state_n = EF_FLAG;
                  fclr    = 1'b1;
               end
            end
            EF_FLAG: begin
               finc = 1'b1;
               dclr = 1'b1;
               if (fcnt == FLAG_LAST) begin
                  state_n = EF_ECHO;
               end
            end
            EF_ECHO: begin
               if (bus_bit) begin
                  dinc = 1'b1;
                  if (dcnt == DELIM_LAST) begin
                     delim_done = 1'b1;
                  end else begin
                     state_n = EF_DELIM;
                  end
               end else begin
                  finc    = 1'b1;
                  ovr_hit = (fcnt == ECHO_LIMIT);
               end
            end
            EF_DELIM: begin
               if (bus_bit) begin
                  dinc = 1'b1;
                  if (dcnt == DELIM_LAST) begin
                     delim_done = 1'b1;
                  end
               end else begin
                  dclr = 1'b1;
               end
            end
            EF_REJOIN: begin
               if (bus_bit) begin
                  rinc = 1'b1;
                  if (rcnt == REJOIN_LAST) begin
                     state_n     = EF_IDLE;
                     release_now = 1'b1;
                  end
               end else begin
                  rclr = 1'b1;
               end
            end
            default: state_n = EF_IDLE;
         endcase
         if (delim_done) begin
            if (passive_q) begin
               state_n = EF_REJOIN;
               rclr    = 1'b1;
            end else begin
               state_n     = EF_IDLE;
               release_now = 1'b1;
            end
         end
      end
   end

   logic ovr_pulse_n;

   if (ECHO_CHECK_EN) begin : g_echo_chk
      assign ovr_pulse_n = ovr_hit;
   end else begin : g_no_echo_chk
      assign ovr_pulse_n = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state        <= EF_IDLE;
         passive_q    <= 1'b0;
         pend_q       <= 1'b0;
         retry_req    <= 1'b0;
         echo_overrun <= 1'b0;
      end else begin
         state        <= state_n;
         retry_req    <= release_now & pend_q;
         echo_overrun <= ovr_pulse_n;
         if (bit_strobe && (state == EF_IDLE) && err_detect) begin
            passive_q <= err_passive;
            pend_q    <= node_tx;
         end
      end
   end

   assign frame_active = (state != EF_IDLE);

   can_ef_drive i_drive (
      .state     (state),
      .passive_q (passive_q),
      .tx_bit    (tx_bit)
   );

endmodule

// File: rtl/can_ef_checker.sv
module can_ef_checker (
   input logic       clk,
   input logic       rst,
   input logic       bit_strobe,
   input logic       err_detect,
   input logic       tx_bit,
   input logic       frame_active,
   input logic       retry_req,
   input logic       echo_overrun,
   input logic       passive_q,
   input logic [2:0] state
);

   // R1: outside a frame the node never drives dominant
   a_r1_idle_recessive: assert property (@(posedge clk) disable iff (rst)
      !frame_active |-> tx_bit);

   // R2: a frame starts only from a strobed error report
   a_r2_start_on_strobe: assert property (@(posedge clk) disable iff (rst)
      $rose(frame_active) |-> $past(bit_strobe && err_detect));

   // R4: a passive frame keeps the line recessive
   a_r4_passive_recessive: assert property (@(posedge clk) disable iff (rst)
      (frame_active && passive_q) |-> tx_bit);

   // R6: overrun is a single-cycle pulse
   a_r6_overrun_single: assert property (@(posedge clk) disable iff (rst)
      echo_overrun |=> !echo_overrun);

   // R9: retry only in the cycle the frame has just ended
   a_r9_retry_at_end: assert property (@(posedge clk) disable iff (rst)
      retry_req |-> (!frame_active && $past(frame_active)));

   // R10: flag type latched for the whole frame
   a_r10_type_held: assert property (@(posedge clk) disable iff (rst)
      (frame_active && $past(frame_active)) |-> $stable(passive_q));

   // R11: the sequence only advances on bit strobes
   a_r11_strobe_paced: assert property (@(posedge clk) disable iff (rst)
      !$past(bit_strobe) |-> $stable(state));

endmodule

bind can_ef_gen can_ef_checker i_can_ef_checker (
   .clk          (clk),
   .rst          (rst),
   .bit_strobe   (bit_strobe),
   .err_detect   (err_detect),
   .tx_bit       (tx_bit),
   .frame_active (frame_active),
   .retry_req    (retry_req),
   .echo_overrun (echo_overrun),
   .passive_q    (passive_q),
   .state        (state)
);

// File: tb/test_can_ef_gen.sv
`timescale 1ns/100ps
module test_can_ef_gen;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic bit_strobe = 1'b0;
   logic bus_bit = 1'b1;
   logic err_detect = 1'b0;
   logic err_passive = 1'b0;
   logic node_tx = 1'b0;
   logic tx_bit, frame_active, retry_req, echo_overrun;

   int n_vec = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   can_ef_gen i_can_ef_gen (
      .clk          (clk),
      .rst          (rst),
      .bit_strobe   (bit_strobe),
      .bus_bit      (bus_bit),
      .err_detect   (err_detect),
      .err_passive  (err_passive),
      .node_tx      (node_tx),
      .tx_bit       (tx_bit),
      .frame_active (frame_active),
      .retry_req    (retry_req),
      .echo_overrun (echo_overrun)
   );

   task automatic check(input string req, input int act, input int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // one bit time: other = 1 means another node drives dominant
   task automatic step(input bit other, input bit ed, output bit drove_dom,
                       output bit ret, output bit ovr);
      @(negedge clk);
      drove_dom   = !tx_bit;
      bus_bit     = tx_bit & !other;
      err_detect  = ed;
      bit_strobe  = 1'b1;
      @(negedge clk);
      bit_strobe  = 1'b0;
      err_detect  = 1'b0;
      ret = retry_req;
      ovr = echo_overrun;
      @(negedge clk);
      ret = ret | retry_req;
      ovr = ovr | echo_overrun;
   endtask

   task automatic run_frame(input bit passive, input bit ntx, input int echo_to,
                            input int dom_at, input int ed_at,
                            output int nbits, output int ndom,
                            output int nret, output int novr);
      bit d, r, o;
      err_passive = passive;
      node_tx     = ntx;
      nbits = 0; ndom = 0; nret = 0; novr = 0;
      step(1'b0, 1'b1, d, r, o);
      node_tx = 1'b0;
      for (int b = 1; b <= 80; b++) begin
         if (!frame_active) break;
         if (b == ed_at) err_passive = !passive;
         step((b <= echo_to) || (b == dom_at), (b == ed_at), d, r, o);
         nbits++;
         ndom += int'(d);
         nret += int'(r);
         novr += int'(o);
      end
      err_passive = 1'b0;
   endtask

   task automatic t_reset;
      check("R1 tx_bit", int'(tx_bit), 1);
      check("R1 frame_active", int'(frame_active), 0);
      check("R1 pulses", int'(retry_req | echo_overrun), 0);
   endtask

   task automatic t_offstrobe;
      @(negedge clk);
      err_detect = 1'b1;
      @(negedge clk);
      err_detect = 1'b0;
      repeat (3) @(negedge clk);
      check("R2 off-strobe error ignored", int'(frame_active), 0);
   endtask

   task automatic t_active_plain;
      int nb, nd, nr, no;
      run_frame(1'b0, 1'b1, 0, 0, 0, nb, nd, nr, no);
      check("R3 dominant flag bits", nd, 6);
      check("R7 R11 frame length 6+8", nb, 14);
      check("R9 retry pulses", nr, 1);
      check("R5 no overrun", no, 0);
   endtask

   task automatic t_echo_fits;
      int nb, nd, nr, no;
      run_frame(1'b0, 1'b1, 12, 0, 0, nb, nd, nr, no);
      check("R5 echo to 12, length 12+8", nb, 20);
      check("R5 no overrun at 12", no, 0);
      check("R3 own flag still 6", nd, 6);
   endtask

   task automatic t_echo_over;
      int nb, nd, nr, no;
      run_frame(1'b0, 1'b0, 13, 0, 0, nb, nd, nr, no);
      check("R6 overrun pulse count", no, 1);
      check("R6 length 13+8", nb, 21);
      check("R9 no retry when not sending", nr, 0);
   endtask

   task automatic t_delim_restart;
      int nb, nd, nr, no;
      run_frame(1'b0, 1'b1, 0, 10, 0, nb, nd, nr, no);
      check("R7 delimiter restart length", nb, 18);
   endtask

   task automatic t_passive;
      int nb, nd, nr, no;
      run_frame(1'b1, 1'b1, 0, 0, 0, nb, nd, nr, no);
      check("R4 no dominant driven", nd, 0);
      check("R8 length 6+8+6", nb, 20);
      check("R9 passive retry", nr, 1);
   endtask

   task automatic t_rejoin_restart;
      int nb, nd, nr, no;
      run_frame(1'b1, 1'b0, 0, 17, 0, nb, nd, nr, no);
      check("R8 rejoin restart length", nb, 23);
      check("R9 passive no retry", nr, 0);
   endtask

   task automatic t_busy_error;
      int nb, nd, nr, no;
      run_frame(1'b0, 1'b1, 0, 0, 3, nb, nd, nr, no);
      check("R10 length unchanged", nb, 14);
      check("R10 flag type unchanged", nd, 6);
      check("R10 retry unchanged", nr, 1);
   endtask

   initial begin
      #(200000 * 5);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      t_reset();
      t_offstrobe();
      t_active_plain();
      t_echo_fits();
      t_echo_over();
      t_delim_restart();
      t_passive();
      t_rejoin_restart();
      t_busy_error();
      t_reset();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule